// File: doc/BRIEF.md
# Exception Priority Threshold Filter

This block holds a programmable base-priority threshold and decides which pending exception requests may activate. Software writes the threshold through a 32-bit register port and can read it back. Each cycle the block takes a vector of pending requests, each carrying an 8-bit priority value. It returns a mask of the requests that are allowed to activate, and it names the most urgent allowed request.

A smaller priority number means a more urgent exception. A threshold of zero turns masking off. Any nonzero threshold blocks every request whose priority is equal to or above it. Only the top `PRIO_BITS` bits of an 8-bit priority are implemented. The unimplemented low bits of the threshold always read as zero, and they are dropped from every request priority before the comparison.

The filter is combinational from the pending inputs to the outputs. Only the threshold is stored. It is meant to sit in front of the activation logic of an exception controller.

Top module: `prio_mask_filter`

## Requirements
- R1: After reset the threshold is zero: `reg_rd_data` reads 0 and every pending request is allowed.
- R2: `reg_rd_data[31:8]` always reads zero, and `reg_rd_data[7:0]` returns the stored threshold.
- R3: Threshold bits [7-PRIO_BITS:0] (bits [4:0] with the default of 3 implemented bits) ignore writes and read as zero. Bits [7:8-PRIO_BITS] store bits [7:8-PRIO_BITS] of `reg_wr_data`.
- R4: While the threshold is zero, `allow_mask` equals `req_pend`.
- R5: While the threshold is nonzero, bit i of `allow_mask` is 1 exactly when request i is pending and its truncated priority is numerically less than the threshold.
- R6: The truncated priority of a request clears its low 8-PRIO_BITS bits. The cleared bits never change `allow_mask` or the winner. For example, with a threshold of 0x60, a priority of 0x5F is allowed and 0x7F is blocked.
- R7: When at least one request is allowed, `win_valid` is 1. `win_id` is the allowed request with the smallest truncated priority, and a tie goes to the lowest index. `win_prio` is that request's truncated priority.
- R8: When no request is allowed, `win_valid`, `win_id` and `win_prio` are all zero.
- R9: A write with `reg_wr_en` high is sampled at the rising edge. Until that edge the mask still uses the old threshold, and from that edge on it uses the new one. Changes on `req_pend` or `req_prio` show on the outputs in the same cycle.
- R10: A write whose implemented bits are all zero (for example 0x1F) leaves a threshold of zero, so masking is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the block leaves reset in step with the clock |
| reg_wr_en | input | 1 | Threshold write strobe |
| reg_wr_data | input | 32 | Threshold write value; bits [7:0] are used |
| reg_rd_data | output | 32 | Threshold read-back |
| req_pend | input | NUM_REQ | Pending request flags |
| req_prio | input | 8*NUM_REQ | Request priorities; request i uses bits [8i+7:8i] |
| allow_mask | output | NUM_REQ | Requests permitted to activate |
| win_valid | output | 1 | At least one request is permitted |
| win_id | output | $clog2(NUM_REQ) | Index of the most urgent permitted request |
| win_prio | output | 8 | Truncated priority of that request |

## Verification
The mask and the winner are combinational from `req_pend` and `req_prio`. A threshold write reaches them only after one rising edge, because the threshold register lies on that path. The bench therefore changes its inputs just after a falling edge and lets the reference model take in a write at the next rising edge. It compares every output at the falling edge that follows.

One directed check looks at the outputs while a write strobe is still high but before its edge. It confirms that the old threshold still governs the mask at that point.

// File: rtl/pmf_pkg.sv
package pmf_pkg;
  localparam int PRIO_W = 8;
  localparam int REG_W  = 32;

  // mask of the implemented (upper) priority bits
  function automatic logic [PRIO_W-1:0] impl_mask(input int bits);
    return ~(8'hFF >> bits);
  endfunction
endpackage

// File: rtl/pmf_rst_sync.sv
module pmf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/pmf_thresh_reg.sv
module pmf_thresh_reg
  import pmf_pkg::*;
#(
  parameter int PRIO_BITS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [PRIO_W-1:0] thr_q,
  output logic [REG_W-1:0]  rd_data
);
  localparam logic [PRIO_W-1:0] IMPL = impl_mask(PRIO_BITS);

  logic [PRIO_W-1:0] thr_d;

  always_comb begin
    thr_d = thr_q;
    if (wr_en) thr_d = wr_data[PRIO_W-1:0] & IMPL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) thr_q <= '0;
    else        thr_q <= thr_d;
  end

  always_comb begin
    rd_data = '0;
    rd_data[PRIO_W-1:0] = thr_q;
  end

  AST_THR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(thr_q)); // R9
  AST_THR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (thr_q == ($past(wr_data[PRIO_W-1:0]) & IMPL))); // R3
endmodule

// File: rtl/pmf_compare.sv
module pmf_compare
  import pmf_pkg::*;
#(
  parameter int NUM_REQ   = 8,
  parameter int PRIO_BITS = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [PRIO_W-1:0]         thr,
  input  logic [NUM_REQ-1:0]        pend,
  input  logic [NUM_REQ*PRIO_W-1:0] prio_raw,
  output logic [NUM_REQ*PRIO_W-1:0] prio_trunc,
  output logic [NUM_REQ-1:0]        allow
);
  localparam logic [PRIO_W-1:0] IMPL = impl_mask(PRIO_BITS);

  logic masking_on;
  assign masking_on = (thr != '0);

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_lane
    logic [PRIO_W-1:0] p_t;
    assign p_t = prio_raw[i*PRIO_W +: PRIO_W] & IMPL;
    assign prio_trunc[i*PRIO_W +: PRIO_W] = p_t;
    assign allow[i] = pend[i] && (!masking_on || (p_t < thr));
  end

  AST_NO_MASK_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (thr == '0) |-> (allow == pend)); // R4
  AST_ALLOW_IN_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (allow & ~pend) == '0); // R5
endmodule

// File: rtl/pmf_select.sv
module pmf_select
  import pmf_pkg::*;
#(
  parameter int NUM_REQ = 8,
  localparam int IDW    = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_REQ-1:0]        allow,
  input  logic [NUM_REQ*PRIO_W-1:0] prio_trunc,
  output logic                      win_valid,
  output logic [IDW-1:0]            win_id,
  output logic [PRIO_W-1:0]         win_prio
);
  always_comb begin
    win_valid = 1'b0;
    win_id    = '0;
    win_prio  = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (allow[i] && (!win_valid || (prio_trunc[i*PRIO_W +: PRIO_W] < win_prio))) begin
        win_valid = 1'b1;
        win_id    = IDW'(i);
        win_prio  = prio_trunc[i*PRIO_W +: PRIO_W];
      end
    end
  end

  AST_WIN_IS_ALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> allow[win_id]); // R7
  AST_IDLE_WHEN_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (allow == '0) |-> (!win_valid && win_id == '0 && win_prio == '0)); // R8

  for (genvar j = 0; j < NUM_REQ; j++) begin : g_chk
    AST_WIN_NOT_BEATEN: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid && allow[j]) |-> (prio_trunc[j*PRIO_W +: PRIO_W] >= win_prio)); // R7
  end
endmodule

// File: rtl/prio_mask_filter.sv
module prio_mask_filter
  import pmf_pkg::*;
#(
  parameter int NUM_REQ   = 8,
  parameter int PRIO_BITS = 3,
  localparam int IDW      = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_wr_en,
  input  logic [31:0]               reg_wr_data,
  output logic [31:0]               reg_rd_data,
  input  logic [NUM_REQ-1:0]        req_pend,
  input  logic [NUM_REQ*8-1:0]      req_prio,
  output logic [NUM_REQ-1:0]        allow_mask,
  output logic                      win_valid,
  output logic [IDW-1:0]            win_id,
  output logic [7:0]                win_prio
);
  logic                      rst_n_s;
  logic [PRIO_W-1:0]         thr;
  logic [NUM_REQ*PRIO_W-1:0] prio_t;

  pmf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  pmf_thresh_reg #(.PRIO_BITS(PRIO_BITS)) u_thr (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (reg_wr_en),
    .wr_data (reg_wr_data),
    .thr_q   (thr),
    .rd_data (reg_rd_data)
  );

  pmf_compare #(.NUM_REQ(NUM_REQ), .PRIO_BITS(PRIO_BITS)) u_cmp (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .thr        (thr),
    .pend       (req_pend),
    .prio_raw   (req_prio),
    .prio_trunc (prio_t),
    .allow      (allow_mask)
  );

  pmf_select #(.NUM_REQ(NUM_REQ)) u_sel (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .allow      (allow_mask),
    .prio_trunc (prio_t),
    .win_valid  (win_valid),
    .win_id     (win_id),
    .win_prio   (win_prio)
  );

  AST_RD_MATCHES_THR: assert property (@(posedge clk) disable iff (!rst_n_s)
    reg_rd_data[31:8] == '0); // R2
endmodule

// File: tb/sim_prio_mask_filter.sv
`timescale 1ns/1ps
module sim_prio_mask_filter;
  localparam int N    = 8;
  localparam int PB   = 3;
  localparam int IW   = 3;
  localparam int IMPL = (255 << (8 - PB)) & 255;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr_en = 1'b0;
  logic [31:0]   reg_wr_data = '0;
  logic [31:0]   reg_rd_data;
  logic [N-1:0]  req_pend = '0;
  logic [N*8-1:0] req_prio = '0;
  logic [N-1:0]  allow_mask;
  logic          win_valid;
  logic [IW-1:0] win_id;
  logic [7:0]    win_prio;

  int total = 0;
  int bad   = 0;
  int mthr  = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  prio_mask_filter #(.NUM_REQ(N), .PRIO_BITS(PB)) u0 (.*);

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", r, act, exp, $time);
    end
  endtask

  // behavioural reference using the model threshold mthr
  task automatic compare_all(input int thr);
    int em = 0; int best = -1; int bp = 0;
    for (int i = 0; i < N; i++) begin
      int p = req_prio[i*8 +: 8] & IMPL;
      if (req_pend[i] && (thr == 0 || p < thr)) begin
        em |= (1 << i);
        if (best < 0 || p < bp) begin best = i; bp = p; end
      end
    end
    chk(thr == 0 ? "R4" : "R5", 32'(allow_mask), 32'(em));
    chk("R2", reg_rd_data, 32'(thr));
    if (best >= 0) begin
      chk("R7", {win_valid, 7'(win_id), win_prio}, {1'b1, 7'(best), 8'(bp)});
    end else begin
      chk("R8", {win_valid, 7'(win_id), win_prio}, 16'h0);
    end
  endtask

  task automatic step();
    @(posedge clk);
    if (reg_wr_en) mthr = reg_wr_data[7:0] & IMPL;
    @(negedge clk);
    compare_all(mthr);
    reg_wr_en = 1'b0;
  endtask

  task automatic wr(input logic [31:0] v);
    reg_wr_en = 1'b1; reg_wr_data = v;
    step();
  endtask

  task automatic set_all_prio(input logic [7:0] v);
    for (int i = 0; i < N; i++) req_prio[i*8 +: 8] = v;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    req_pend = 8'hA5; set_all_prio(8'hFF);
    #1;
    chk("R1", reg_rd_data, 32'h0);
    chk("R1", 32'(allow_mask), 32'hA5);
    step();

    // R2 / R3: only implemented bits stored
    wr(32'hFFFF_FFFF);
    chk("R3", reg_rd_data, 32'(IMPL));
    wr(32'h1234_5678);
    chk("R3", reg_rd_data, 32'h60);
    // R10: only unimplemented bits written
    wr(32'h0000_001F);
    chk("R10", reg_rd_data, 32'h0);
    chk("R10", 32'(allow_mask), 32'hA5);

    // R6: low bits ignored, threshold 0x60
    wr(32'h60);
    req_pend = 8'h03;
    req_prio[7:0] = 8'h5F; req_prio[15:8] = 8'h7F;
    step();
    chk("R6", 32'(allow_mask), 32'h1);
    req_prio[7:0] = 8'h40; req_prio[15:8] = 8'h5F;
    step();
    chk("R6", {win_valid, 7'(win_id), win_prio}, {1'b1, 7'd0, 8'h40});

    // R7: ties go to lowest index
    wr(32'h0);
    req_pend = 8'hF0; set_all_prio(8'h20);
    step();
    chk("R7", 32'(win_id), 32'd4);
    req_prio[63:56] = 8'h00;
    step();
    chk("R7", 32'(win_id), 32'd7);

    // R8: all blocked
    wr(32'h20);
    req_pend = 8'hFF; set_all_prio(8'h20);
    step();
    chk("R8", 32'(win_valid), 32'd0);

    // R9: write not visible before its edge, inputs visible same cycle
    wr(32'h0);
    req_pend = 8'h0F; set_all_prio(8'h80);
    reg_wr_en = 1'b1; reg_wr_data = 32'h40;
    #1;
    chk("R9", 32'(allow_mask), 32'h0F);
    step();
    chk("R9", 32'(allow_mask), 32'h00);
    req_prio[7:0] = 8'h20;
    #1;
    chk("R9", 32'(allow_mask), 32'h01);
    step();

    // mixed patterns
    for (int k = 0; k < 400; k++) begin
      req_pend = N'($urandom);
      for (int i = 0; i < N; i++) req_prio[i*8 +: 8] = 8'($urandom);
      if (($urandom % 4) == 0) begin
        reg_wr_en = 1'b1; reg_wr_data = $urandom;
        if (($urandom % 3) == 0) reg_wr_data[7:0] = 8'h00;
      end
      step();
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule